// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles and returns the full double-width product. It is built around one double-width accumulator. The upper half of the accumulator starts at zero. The lower half is preloaded with the multiplier, and the low bits are consumed as the accumulator shifts right. A separate register holds the multiplicand. One single-width ripple adder adds the multiplicand into the upper half whenever the current low bit of the accumulator is one. The adder's carry-out enters the top bit during the shift, so no sum bit is lost. The result is never truncated and never flagged as overflowing.

A request is offered on `req_valid` together with both operands. It is taken on a clock edge where `req_ready` is also high. `req_ready` is high exactly while the unit is idle, so the requester sees back-pressure for the whole computation. There is no queue: while the unit is busy, requests are not taken and the operand pins are not looked at. The result side has no back-pressure. `done` is a one-cycle pulse, and `product` keeps the finished value until the next request is accepted. The consumer can therefore read the value on the pulse or at any time afterwards.

Top module: `seq_mul`

## Requirements
- R1: While `rst_n` is low, `busy` and `done` are 0, `req_ready` is 1 and `product` is all zeros.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From the following cycle, `busy` is 1 and `req_ready` is 0.
- R3: The finished `product` equals the unsigned product of the two accepted operands, with all 2*WIDTH bits kept. This includes the all-ones times all-ones case, where the carry-out of the adder must reach the top bit.
- R4: `done` rises exactly WIDTH clock edges after the accepting edge, is high for exactly one cycle, and falls together with `busy`.
- R5: Changes on `req_valid`, `req_mcand` or `req_mplier` while `busy` is 1 do not change the result of the computation in progress.
- R6: While idle, `product` holds its value until the next request is accepted.
- R7: A zero operand on either side gives an all-zero product.
- R8: With WIDTH=4, operands 4'b0010 and 4'b0011 give the product 8'b0000_0110.
- R9: A new request offered during the `done` cycle is accepted at once, and `busy` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request with operands is offered |
| req_ready | output | 1 | The unit is idle and takes an offered request |
| req_mcand | input | WIDTH | Multiplicand operand |
| req_mplier | input | WIDTH | Multiplier operand |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Unsigned double-width product, held while idle |

## Verification
The bench builds two instances of the block side by side.

The first uses the default WIDTH of 32. It walks a table of operand pairs, including all-ones times all-ones, single-bit and zero operands. On that instance the bench also checks that operand and valid activity during a computation is ignored, and that a request offered in the done cycle is accepted at once.

The second is built with WIDTH=4. The short operand space makes an exhaustive sweep of all 256 operand pairs practical, which exercises every carry path of the shared adder. The same sweep checks the latency on every run, and it covers the small 2 times 3 worked case.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

  // Sequencer state of the multiplier
  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/seq_mul_adder.sv
// Ripple-carry adder of WIDTH bits with carry-out, built from full-adder cells.
module seq_mul_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic half;
    assign half       = op_a[i] ^ op_b[i];
    assign sum[i]     = half ^ carry[i];
    assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & half);
  end

  assign carry_out = carry[WIDTH];

endmodule

// File: rtl/seq_mul_ctrl.sv
// Step sequencer: accepts a request, runs WIDTH steps, then pulses done.
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mul_state_e       state_q;
  mul_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign busy      = (state_q == MS_RUN);
  assign req_ready = ~busy;
  assign load      = req_valid & req_ready;
  assign step      = busy;
  assign last      = (cnt_q == LAST_STEP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MS_IDLE: if (load)        state_d = MS_RUN;
      MS_RUN:  if (last)        state_d = MS_IDLE;
      default:                  state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= busy & last;
      if (load)      cnt_q <= '0;
      else if (busy) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/seq_mul_datapath.sv
// Multiplicand register and shared product/multiplier accumulator.
module seq_mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    acc_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] upper_sum;
  logic             upper_cout;
  logic [PW-1:0]    acc_next;

  // Add the multiplicand only when the current low bit is one
  assign addend = mcand_q & {WIDTH{acc_q[0]}};

  seq_mul_adder #(.WIDTH(WIDTH)) u_add (
    .op_a      (acc_q[PW-1:WIDTH]),
    .op_b      (addend),
    .sum       (upper_sum),
    .carry_out (upper_cout)
  );

  // Shift right by one; the carry-out enters the top bit
  assign acc_next = {upper_cout, upper_sum, acc_q[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      acc_q   <= {{WIDTH{1'b0}}, mplier_in};
    end else if (step) begin
      acc_q   <= acc_next;
    end
  end

  assign product = acc_q;

endmodule

// File: rtl/seq_mul.sv
// Top: sequential unsigned shift-add multiplier.
module seq_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WIDTH-1:0]   req_mcand,
  input  logic [WIDTH-1:0]   req_mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  logic load;
  logic step;

  seq_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .load      (load),
    .step      (step),
    .busy      (busy),
    .done      (done)
  );

  seq_mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (req_mcand),
    .mplier_in (req_mplier),
    .product   (product)
  );

endmodule

// File: rtl/seq_mul_chk.sv
// Property checker bound to seq_mul.
module seq_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [WIDTH-1:0]   req_mcand,
  input logic [WIDTH-1:0]   req_mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int RUN_W = $clog2(WIDTH) + 2;

  logic               take;
  logic [WIDTH-1:0]   ref_a_q;
  logic [WIDTH-1:0]   ref_b_q;
  logic [RUN_W-1:0]   run_q;
  logic [2*WIDTH-1:0] ref_prod;

  assign take     = req_valid & req_ready;
  assign ref_prod = {{WIDTH{1'b0}}, ref_a_q} * {{WIDTH{1'b0}}, ref_b_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_a_q <= '0;
      ref_b_q <= '0;
      run_q   <= '0;
    end else if (take) begin
      ref_a_q <= req_mcand;
      ref_b_q <= req_mplier;
      run_q   <= '0;
    end else if (busy) begin
      run_q   <= run_q + 1'b1;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy && !req_ready));

  // R3
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_prod));

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q == RUN_W'(WIDTH)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(busy) && !busy));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> $stable(product));

endmodule

bind seq_mul seq_mul_chk #(.WIDTH(WIDTH)) u_seq_mul_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mcand  (req_mcand),
  .req_mplier (req_mplier),
  .busy       (busy),
  .done       (done),
  .product    (product)
);

// File: tb/seq_mul_bench.sv
module seq_mul_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Wide instance (default WIDTH=32)
  logic        w_valid = 1'b0;
  logic        w_ready;
  logic [31:0] w_a = '0;
  logic [31:0] w_b = '0;
  logic        w_busy;
  logic        w_done;
  logic [63:0] w_prod;

  seq_mul u_seq_mul (
    .clk(clk), .rst_n(rst_n), .req_valid(w_valid), .req_ready(w_ready),
    .req_mcand(w_a), .req_mplier(w_b), .busy(w_busy), .done(w_done),
    .product(w_prod)
  );

  // Narrow instance (WIDTH=4)
  logic       n_valid = 1'b0;
  logic       n_ready;
  logic [3:0] n_a = '0;
  logic [3:0] n_b = '0;
  logic       n_busy;
  logic       n_done;
  logic [7:0] n_prod;

  seq_mul #(.WIDTH(4)) u_seq_mul_nar (
    .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_ready(n_ready),
    .req_mcand(n_a), .req_mplier(n_b), .busy(n_busy), .done(n_done),
    .product(n_prod)
  );

  // Operand pairs {multiplicand, multiplier}
  localparam int NV = 10;
  localparam logic [63:0] VECS [0:NV-1] = '{
    {32'h0000_0002, 32'h0000_0003},
    {32'h0000_0000, 32'hDEAD_BEEF},
    {32'hCAFE_F00D, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h0000_0001, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h0000_0002},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'hFFFF_0000, 32'h0000_FFFF},
    {32'h8000_0001, 32'h8000_0001}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One wide run; if noisy, toggles inputs while busy (R5).
  task automatic run_wide(input logic [31:0] a, input logic [31:0] b,
                          input bit noisy, input string req);
    logic [63:0] exp;
    int cyc;
    exp = {32'h0, a} * {32'h0, b};
    @(negedge clk);
    w_valid = 1'b1; w_a = a; w_b = b;
    check(w_ready == 1'b1, "R2 ready before accept", {63'h0, w_ready}, 64'h1);
    @(negedge clk);
    check(w_busy == 1'b1 && w_ready == 1'b0, "R2 busy after accept",
          {62'h0, w_busy, w_ready}, 64'h2);
    w_valid = noisy; w_a = ~a; w_b = b ^ 32'h5A5A_A5A5;
    cyc = 0;
    while (!w_done && cyc < 100) begin
      if (cyc == 28) w_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    w_valid = 1'b0;
    check(cyc == 32, "R4 latency", 64'(cyc), 64'd32);
    check(w_prod == exp, req, w_prod, exp);
    check(w_busy == 1'b0, "R4 busy falls with done", {63'h0, w_busy}, 64'h0);
    @(negedge clk);
    check(w_done == 1'b0, "R4 done single pulse", {63'h0, w_done}, 64'h0);
    repeat (3) @(negedge clk);
    check(w_prod == exp, "R6 product held idle", w_prod, exp);
  endtask

  task automatic run_narrow(input logic [3:0] a, input logic [3:0] b,
                            input string req);
    logic [7:0] exp;
    int cyc;
    exp = {4'h0, a} * {4'h0, b};
    @(negedge clk);
    n_valid = 1'b1; n_a = a; n_b = b;
    @(negedge clk);
    n_valid = 1'b0;
    cyc = 0;
    while (!n_done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 4, "R4 latency narrow", 64'(cyc), 64'd4);
    check(n_prod == exp, req, {56'h0, n_prod}, {56'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(w_busy == 1'b0 && w_done == 1'b0 && w_ready == 1'b1, "R1 wide flags",
          {61'h0, w_busy, w_done, w_ready}, 64'h1);
    check(w_prod == 64'h0, "R1 wide product", w_prod, 64'h0);
    check(n_busy == 1'b0 && n_done == 1'b0 && n_ready == 1'b1 && n_prod == 8'h0,
          "R1 narrow", {53'h0, n_busy, n_done, n_ready, n_prod}, 64'h100);
    rst_n = 1'b1;

    // R3 R7: table walk on the wide instance
    for (int i = 0; i < NV; i++)
      run_wide(VECS[i][63:32], VECS[i][31:0], 1'b0, "R3 R7 table product");

    // R5: noisy inputs while busy
    run_wide(32'h0F0F_1234, 32'h0000_ABCD, 1'b1, "R5 noise ignored");
    run_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 R3 max noise ignored");

    // R9: back-to-back request in the done cycle
    begin
      int cyc;
      @(negedge clk);
      w_valid = 1'b1; w_a = 32'd7; w_b = 32'd9;
      @(negedge clk);
      w_valid = 1'b0;
      cyc = 0;
      while (!w_done && cyc < 100) begin @(negedge clk); cyc++; end
      check(w_prod == 64'd63, "R9 first product", w_prod, 64'd63);
      w_valid = 1'b1; w_a = 32'd100; w_b = 32'd1000;
      @(negedge clk);
      check(w_busy == 1'b1, "R9 accepted in done cycle", {63'h0, w_busy}, 64'h1);
      w_valid = 1'b0;
      cyc = 0;
      while (!w_done && cyc < 100) begin @(negedge clk); cyc++; end
      check(w_prod == 64'd100000, "R9 second product", w_prod, 64'd100000);
    end

    // R8: worked small case
    run_narrow(4'b0010, 4'b0011, "R8 two times three");
    check(n_prod == 8'b0000_0110, "R8 exact pattern", {56'h0, n_prod}, 64'h6);

    // R3: exhaustive narrow sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_narrow(4'(a), 4'(b), "R3 narrow exhaustive");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule